// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Control Bus

This block is the control-register port of a clock synthesizer. It sits on a two-wire SMBus segment, with SCL as an input and SDA open-drain, and it owns a small file of configuration bytes. The rest of the chip reads these bytes continuously from a flat parallel output. The block runs on a fast local clock. It oversamples both bus lines, filters them, and finds clock edges, START and STOP conditions from the filtered levels.

A host writes by sending the device address, a starting index, a byte count and then that many data bytes. The block stores the data bytes at consecutive indices. A host reads by sending the device address and an index, then a repeated START and the device address with the read bit set. The block answers with a count byte taken from a writable register. It then streams register bytes from the index upward until the host stops acknowledging.

Some bits are fixed identification values, and some are frequency-select strap levels captured just after reset. Both kinds are read-only and ignore writes. Writes to them are still acknowledged, so a block write can pass over them.

Top module: `smbIndexedRegs`

## Requirements
- R1: After reset the register image holds 0xFF in byte 0, 0xF6 in byte 1, 0xFF in byte 2, 0xFE in byte 3, 0x18 plus the strap value in byte 6, 0x21 in byte 7, 0x08 in byte 8, 0x0C in byte 9, 0x03 in byte 10, and 0x00 in every other byte (bytes 4, 5 and 11 through 21).
- R2: The block acknowledges the 8-bit address bytes 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and the rest of that transaction, up to the next START or STOP, is ignored without change to any register.
- R3: A block write is address 0xD2, index N, count X and then data bytes. The block acknowledges every one of these bytes and stores the data bytes at N, N+1, ... N+X-1.
- R4: Once X data bytes have been accepted, any further data byte is not acknowledged and is not stored.
- R5: A block read is 0xD2, index N, repeated START, 0xD3. The block first returns the current value of byte 8, then bytes N, N+1, ... for as long as the host acknowledges. After a host NACK the block leaves SDA released until the next START.
- R6: Byte 7, byte 9 and bits 2:0 of byte 6 are read-only. Writes to them are acknowledged and leave them unchanged. Bits 2:0 of byte 6 show the 3-bit strap input as sampled on the first clock after reset; later strap changes do not appear.
- R7: The index steps from 21 back to 0. A starting index of 22 or above reads as 0x00, ignores writes, and steps to 0 for the next byte.
- R8: The parallel output carries byte i of the register image on bits 8*i+7 down to 8*i at all times.
- R9: The block changes its SDA drive only while SCL is low. An acknowledge is driven during the ninth clock of a received byte.
- R10: A STOP ends any transaction and releases SDA. A START seen in the middle of a byte discards that partial byte and begins a new address phase.
- R11: Writing byte 8 changes the count byte returned at the start of later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, as seen on the wire |
| sdaOe | output | 1 | Pull the data line low when 1 |
| strapIn | input | 3 | Frequency-select strap levels, captured after reset |
| regsOut | output | NUM_REGS*8 | Flat register image, byte i at bits 8*i+7 down to 8*i |

## Verification
The bench builds the block with its defaults: NUM_REGS of 22, FILT_LEN of 3 and the 7-bit address 0x69. With 22 bytes, a read of four bytes from index 20 crosses the wrap point, and an index of 30 falls outside the file. The filter depth of 3, against bus phases of 16 local clocks, leaves room for the acknowledge to settle before SCL rises. A START after four bits of a byte checks that the partial byte is thrown away.

// File: rtl/smbRegPkg.sv
package smbRegPkg;

  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       loadIdx;  // take data as the new index
    logic       incIdx;   // step index after a read byte
    logic       wrEn;     // store data at index, then step index
    logic [7:0] data;
  } regStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA, ST_RDATA, ST_WAIT
  } busStateT;

  localparam int STRAP_BYTE = 6;
  localparam int CNT_BYTE   = 8;

  function automatic logic [7:0] resetValue(input int i);
    case (i)
      0:       return 8'hFF;
      1:       return 8'hF6;
      2:       return 8'hFF;
      3:       return 8'hFE;
      6:       return 8'h18;
      8:       return 8'h08;
      10:      return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] roMask(input int i);
    case (i)
      6:       return 8'h07;
      7, 9:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixedValue(input int i);
    case (i)
      7:       return 8'h21;
      9:       return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbLineFilter.sv
module smbLineFilter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  // index 1 = SCL, index 0 = SDA
  logic [1:0] rawIn;
  logic [1:0] lvl;
  logic [1:0] lvlPrev;

  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [1:0]          syncQ;
    logic [FILT_LEN-1:0] hist;
    logic                lvlQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        hist  <= '1;
        lvlQ  <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        hist  <= {hist[FILT_LEN-2:0], syncQ[1]};
        if (&hist)       lvlQ <= 1'b1;
        else if (~|hist) lvlQ <= 1'b0;
      end
    end
    assign lvl[g] = lvlQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= '1;
    else       lvlPrev <= lvl;
  end

  assign sclLvl   = lvl[1];
  assign sdaLvl   = lvl[0];
  assign sclRise  = lvl[1] & ~lvlPrev[1];
  assign sclFall  = ~lvl[1] & lvlPrev[1];
  assign startDet = lvl[1] & lvlPrev[1] & lvlPrev[0] & ~lvl[0];
  assign stopDet  = lvl[1] & lvlPrev[1] & ~lvlPrev[0] & lvl[0];

endmodule

// File: rtl/smbBusCtrl.sv
module smbBusCtrl
  import smbRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rdData,
  input  logic [7:0] cntByte,
  output regStrobeT  strb,
  output logic       sdaOe
);
  busStateT   state, nextState;
  logic [3:0] bitCnt;
  logic       inAck, ackSeen, hostAck;
  logic [7:0] shiftQ, txByte, remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nextState <= ST_IDLE;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      ackSeen   <= 1'b0;
      hostAck   <= 1'b0;
      shiftQ    <= '0;
      txByte    <= '0;
      remain    <= '0;
      sdaOe     <= 1'b0;
      strb      <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        ackSeen <= 1'b0;
        sdaOe   <= 1'b0;
      end else if (stopDet) begin
        state   <= ST_IDLE;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        ackSeen <= 1'b0;
        sdaOe   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE, ST_WAIT: ;
          ST_RDATA: begin
            if (sclRise) begin
              if (bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
              else begin
                ackSeen <= 1'b1;
                hostAck <= ~sdaLvl;
              end
            end else if (sclFall) begin
              if (ackSeen) begin
                ackSeen <= 1'b0;
                if (hostAck) begin
                  txByte      <= rdData;
                  sdaOe       <= ~rdData[7];
                  strb.incIdx <= 1'b1;
                  bitCnt      <= '0;
                end else begin
                  state <= ST_WAIT;
                  sdaOe <= 1'b0;
                end
              end else if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;  // hand the line to the host for its ack
              end else begin
                sdaOe <= ~txByte[3'd7 - bitCnt[2:0]];
              end
            end
          end
          default: begin  // receiving: address, index, count, data
            if (sclRise && !inAck && bitCnt < 4'd8) begin
              shiftQ <= {shiftQ[6:0], sdaLvl};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && inAck) begin
              inAck  <= 1'b0;
              bitCnt <= '0;
              state  <= nextState;
              sdaOe  <= 1'b0;
              if (nextState == ST_RDATA) begin
                txByte <= cntByte;
                sdaOe  <= ~cntByte[7];
              end
            end else if (sclFall && bitCnt == 4'd8) begin
              inAck <= 1'b1;
              case (state)
                ST_ADDR: begin
                  if (shiftQ[7:1] == DEV_ADDR) begin
                    sdaOe     <= 1'b1;
                    nextState <= shiftQ[0] ? ST_RDATA : ST_INDEX;
                  end else begin
                    nextState <= ST_WAIT;
                  end
                end
                ST_INDEX: begin
                  sdaOe        <= 1'b1;
                  strb.loadIdx <= 1'b1;
                  strb.data    <= shiftQ;
                  nextState    <= ST_COUNT;
                end
                ST_COUNT: begin
                  sdaOe     <= 1'b1;
                  remain    <= shiftQ;
                  nextState <= ST_WDATA;
                end
                default: begin
                  if (remain != 8'd0) begin
                    sdaOe     <= 1'b1;
                    strb.wrEn <= 1'b1;
                    strb.data <= shiftQ;
                    remain    <= remain - 8'd1;
                    nextState <= ST_WDATA;
                  end else begin
                    nextState <= ST_WAIT;
                  end
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  // SDA drive may only move while the filtered SCL is low
  assert_sda_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaOe));

  // A STOP always leaves the line released
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // Every stored data byte is acknowledged
  assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> sdaOe);

endmodule

// File: rtl/smbRegFile.sv
module smbRegFile
  import smbRegPkg::*;
#(
  parameter int NUM_REGS = 22
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobeT             strb,
  input  logic [2:0]            strapIn,
  output logic [7:0]            rdData,
  output logic [7:0]            cntByte,
  output logic [NUM_REGS*8-1:0] regsOut
);
  localparam int LAST     = NUM_REGS - 1;
  localparam int IDX_BITS = $clog2(NUM_REGS);

  logic [7:0] idxQ;
  logic [2:0] strapQ;
  logic       strapDone;
  logic [7:0] view [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ    <= '0;
      strapDone <= 1'b0;
    end else if (!strapDone) begin
      strapQ    <= strapIn;
      strapDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxQ <= '0;
    else if (strb.loadIdx) idxQ <= strb.data;
    else if (strb.incIdx || strb.wrEn)
      idxQ <= (idxQ >= 8'(LAST)) ? 8'd0 : idxQ + 8'd1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gByte
    localparam logic [7:0] RW_MASK = ~roMask(i);
    logic [7:0] storeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) storeQ <= resetValue(i) & RW_MASK;
      else if (strb.wrEn && idxQ == 8'(i)) storeQ <= strb.data & RW_MASK;
    end
    if (i == STRAP_BYTE) begin : gStrap
      assign view[i] = storeQ | {5'd0, strapQ};
    end else begin : gPlain
      assign view[i] = storeQ | (fixedValue(i) & ~RW_MASK);
    end
    assign regsOut[i*8 +: 8] = view[i];
  end

  assign rdData  = (idxQ < 8'(NUM_REGS)) ? view[idxQ[IDX_BITS-1:0]] : 8'h00;
  assign cntByte = view[CNT_BYTE];

  // Index steps from the top of the file back to zero
  assert_index_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.incIdx || strb.wrEn) && !strb.loadIdx && idxQ >= 8'(LAST)) |=> (idxQ == 8'd0));

  // A write beyond the file changes nothing
  assert_oor_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && idxQ >= 8'(NUM_REGS)) |=> $stable(regsOut));

  // Fully read-only bytes ignore writes
  assert_ro_byte_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && (idxQ == 8'd7 || idxQ == 8'd9)) |=> $stable(regsOut));

endmodule

// File: rtl/smbIndexedRegs.sv
module smbIndexedRegs
  import smbRegPkg::*;
#(
  parameter int         NUM_REGS = 22,
  parameter int         FILT_LEN = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [2:0]            strapIn,
  output logic [NUM_REGS*8-1:0] regsOut
);
  logic       sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rdData, cntByte;
  regStrobeT  strb;

  smbLineFilter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smbBusCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rdData(rdData), .cntByte(cntByte), .strb(strb), .sdaOe(sdaOe)
  );

  smbRegFile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .strapIn(strapIn),
    .rdData(rdData), .cntByte(cntByte), .regsOut(regsOut)
  );

endmodule

// File: tb/smbIndexedRegs_bench.sv
module smbIndexedRegs_bench;
  localparam int NREG = 22;
  localparam int Q    = 16;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [2:0] strapIn = 3'b101;
  logic sdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regsOut;

  assign sdaLine = sdaDrv & ~sdaOe;  // open-drain wire
  always #10 clk = ~clk;             // 50 MHz

  smbIndexedRegs #(.NUM_REGS(NREG)) u_smbIndexedRegs (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .strapIn(strapIn), .regsOut(regsOut)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];

  typedef struct {
    logic [7:0] v;
    string      tag;
  } expT;
  expT        expQ[$];
  event       gotByte;
  logic [7:0] gotVal;

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(gotByte);
      if (expQ.size() == 0) check(1'b0, "R5 unexpected read byte", gotVal, 8'h00);
      else begin
        expT e;
        e = expQ.pop_front();
        check(gotVal == e.v, e.tag, gotVal, e.v);
      end
    end
  end

  function automatic logic [7:0] roOf(input int i);
    if (i == 6) return 8'h07;
    if (i == 7 || i == 9) return 8'hFF;
    return 8'h00;
  endfunction
  function automatic int idxNext(input int i);
    return (i >= NREG - 1) ? 0 : i + 1;
  endfunction
  function automatic logic [7:0] valAt(input int i);
    return (i < NREG) ? model[i] : 8'h00;
  endfunction
  task automatic modelWrite(input int i, input logic [7:0] v);
    if (i < NREG) model[i] = (model[i] & roOf(i)) | (v & ~roOf(i));
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask
  task automatic busStart();
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b0; waitQ();
  endtask
  task automatic busStop();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ();
  endtask
  task automatic writeBit(input logic b);
    sdaDrv = b; waitQ(); sclDrv = 1'b1; waitQ(); waitQ(); sclDrv = 1'b0; waitQ();
  endtask
  task automatic readBit(output logic b);
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ(); b = sdaLine; waitQ(); sclDrv = 1'b0; waitQ();
  endtask
  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic a;
    for (int k = 7; k >= 0; k--) writeBit(v[k]);
    readBit(a);
    ack = ~a;
  endtask
  task automatic recvByte(output logic [7:0] v, input logic ackIt);
    logic b;
    for (int k = 7; k >= 0; k--) begin readBit(b); v[k] = b; end
    writeBit(~ackIt);
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < NREG; i++)
      check(regsOut[i*8 +: 8] == model[i], tag, regsOut[i*8 +: 8], model[i]);
  endtask

  task automatic blockWrite(input int idx, input int cnt, input logic [7:0] dq[$], input string tag);
    logic ack;
    int p;
    p = idx;
    busStart();
    sendByte(8'hD2, ack); check(ack, {tag, " R2/R9 addr ack"}, 8'(ack), 8'h01);
    sendByte(8'(idx), ack); check(ack, {tag, " R3 index ack"}, 8'(ack), 8'h01);
    sendByte(8'(cnt), ack); check(ack, {tag, " R3 count ack"}, 8'(ack), 8'h01);
    foreach (dq[k]) begin
      sendByte(dq[k], ack);
      if (k < cnt) begin
        check(ack, {tag, " R3 data ack"}, 8'(ack), 8'h01);
        modelWrite(p, dq[k]);
        p = idxNext(p);
      end else begin
        check(!ack, {tag, " R4 extra byte nack"}, 8'(ack), 8'h00);
      end
    end
    busStop();
  endtask

  task automatic blockRead(input int idx, input int n, input string tag, input logic glitch);
    logic ack;
    logic [7:0] v;
    int p;
    if (glitch) begin  // R10: partial byte cut off by a START
      busStart();
      for (int b = 0; b < 4; b++) writeBit(1'b1);
    end
    busStart();
    sendByte(8'hD2, ack); check(ack, {tag, " R2/R9 addr ack"}, 8'(ack), 8'h01);
    sendByte(8'(idx), ack); check(ack, {tag, " R5 index ack"}, 8'(ack), 8'h01);
    busStart();
    sendByte(8'hD3, ack); check(ack, {tag, " R2 read addr ack"}, 8'(ack), 8'h01);
    expQ.push_back('{model[8], {tag, " R5/R11 count byte"}});
    p = idx;
    for (int k = 0; k < n; k++) begin
      expQ.push_back('{valAt(p), {tag, " R5 data byte"}});
      p = idxNext(p);
    end
    for (int k = 0; k <= n; k++) begin
      recvByte(v, k < n);
      gotVal = v;
      ->gotByte;
      waitQ();
    end
    check(!sdaOe, {tag, " R5 released after nack"}, 8'(sdaOe), 8'h00);
    busStop();
  endtask

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] dq[$];
    logic ack;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[0] = 8'hFF; model[1] = 8'hF6; model[2] = 8'hFF; model[3] = 8'hFE;
    model[6] = 8'h18 | 8'h05; model[7] = 8'h21; model[8] = 8'h08;
    model[9] = 8'h0C; model[10] = 8'h03;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    strapIn = 3'b010;  // R6: later strap change must not show
    checkRegs("R1 reset image");

    blockRead(0, 10, "R5 read from zero", 1'b0);

    dq = {8'hA5, 8'h5A, 8'h3C};
    blockWrite(3, 3, dq, "R3 three bytes");
    checkRegs("R8 image after write");
    blockRead(3, 3, "R3 readback", 1'b0);

    dq = {8'h81, 8'h99};
    blockWrite(2, 1, dq, "R4 count limit");
    checkRegs("R4 extra byte dropped");

    dq = {8'hFF, 8'h00, 8'h04, 8'h77};
    blockWrite(6, 4, dq, "R6 read-only span");
    checkRegs("R6 read-only bits kept");
    blockRead(5, 5, "R11 new count", 1'b0);

    // R2: foreign address
    busStart();
    sendByte(8'hA0, ack); check(!ack, "R2 foreign addr nack", 8'(ack), 8'h00);
    sendByte(8'h03, ack); check(!ack, "R2 ignored index", 8'(ack), 8'h00);
    sendByte(8'h01, ack); check(!ack, "R2 ignored count", 8'(ack), 8'h00);
    sendByte(8'h99, ack); check(!ack, "R2 ignored data", 8'(ack), 8'h00);
    busStop();
    checkRegs("R2 foreign address no change");

    dq = {8'h11, 8'h22, 8'h33};
    blockWrite(20, 3, dq, "R7 wrap write");
    blockRead(20, 4, "R7 wrap read", 1'b0);

    dq = {8'hAA, 8'hBB};
    blockWrite(30, 2, dq, "R7 out of range write");
    checkRegs("R7 out of range image");
    blockRead(30, 2, "R7 out of range read", 1'b0);

    blockRead(0, 3, "R10 restart mid byte", 1'b1);
    checkRegs("R10 image after restart");

    check(expQ.size() == 0, "R5 scoreboard drained", 8'(expQ.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule